// File: doc/BRIEF.md
# Interrupt Polarity and Latch Front End

This block sits between a set of peripheral interrupt request wires and a downstream interrupt controller that accepts only active-high level inputs. Each request wire is first brought into the local clock domain, then optionally inverted so that active-low or falling-edge sources look like active-high ones. Lines built as level type pass straight through. Lines built as edge type capture a detected edge in a pending flop and hold their output high until software acknowledges them.

Software controls three banks of 16-bit registers over a simple synchronous bus. The mask bank blocks individual outputs. The polarity bank selects inversion. Writing ones to the acknowledge bank clears pending edge requests. The acknowledge scheme can be removed at build time. In that variant an edge request stays pending only while its adjusted input remains active, and acknowledge writes do nothing. The number of lines, the edge/level choice for each line and the acknowledge option are all parameters.

Top module: `irq_level_front`

## Requirements
- R1: The line count is a parameter from 1 to 64. Register bits for lines that do not exist, and whole words above the last line, ignore writes and read as zero.
- R2: The register offset is given by reg_addr[5:4]: 0 selects the mask bank at 0x00, 1 the polarity bank at 0x10 and 2 the acknowledge bank at 0x20. reg_addr[3:2] selects the word. Line n uses bit (n mod 16) of the word at bank offset + (n/16)*4.
- R3: After reset every existing mask bit reads 1, every polarity bit reads 0, no request is pending and every output is low.
- R4: A mask bit of 1 holds the line's output low, and a mask bit of 0 lets it through. An edge captured while a line is masked stays pending and appears on the output as soon as the mask bit is cleared.
- R5: A polarity bit of 1 inverts the synchronized input, so a low level or a falling edge counts as active. A polarity bit of 0 treats a high level or a rising edge as active.
- R6: On a level line, the output equals the polarity-adjusted input gated by the mask. It follows a change on irq_raw after two clock edges and keeps no memory of past requests.
- R7: On an edge line, an active edge sets the pending flop, and the output rises on the third clock edge after the input change. It then stays high after the input returns to inactive.
- R8: With acknowledge enabled, writing 1 to a line's acknowledge bit clears that line's pending request on the same edge, and bits written as 0 leave their lines unchanged. If a new active edge is detected in the cycle of the write, the request stays pending.
- R9: The acknowledge bank always reads as zero.
- R10: With acknowledge disabled, acknowledge writes have no effect. A pending edge request clears on the clock edge after its adjusted input becomes inactive.
- R11: reg_rdata presents the addressed word on the cycle after reg_rd is sampled high, and reads zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NUM_LINES | Asynchronous request wires from peripherals |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_rd | input | 1 | Read strobe, sampled on the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the read strobe |
| irq_out | output | NUM_LINES | Active-high level requests toward the downstream controller |

## Verification
The hardest case to reach is an acknowledge write that arrives in the same cycle in which a fresh edge is detected on a line that is already pending. From the ports, the edge-detect pulse exists only between the second and third clock edges after the input change. The stimulus therefore raises the line, waits exactly two edges and then issues the write, so the write strobe is sampled together with the detect pulse. A second write one cycle later confirms that the request clears once no edge coincides. A second instance, built without acknowledge, receives the same stimulus so that the two clearing rules can be compared side by side.

// File: rtl/ilf_pkg.sv
package ilf_pkg;

    localparam int MAX_LINES = 64;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 6;

    typedef enum logic [1:0] {
        BANK_MASK = 2'd0,
        BANK_POL  = 2'd1,
        BANK_ACK  = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [1:0] word;
    } reg_sel_t;

    typedef struct packed {
        logic pol;
        logic mask;
        logic ack;
    } line_ctl_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.bank = bank_e'(a[5:4]);
        s.word = a[3:2];
        return s;
    endfunction

    function automatic int words_for(input int n);
        return (n + WORD_W - 1) / WORD_W;
    endfunction

    function automatic logic [MAX_LINES-1:0] line_valid(input int n);
        logic [MAX_LINES-1:0] v;
        for (int b = 0; b < MAX_LINES; b++) v[b] = (b < n);
        return v;
    endfunction

endpackage

// File: rtl/ilf_sync.sv
module ilf_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/ilf_regs.sv
module ilf_regs
    import ilf_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] mask_vec,
    output logic [NUM_LINES-1:0] pol_vec,
    output logic [NUM_LINES-1:0] ack_vec
);
    localparam int NWORDS = words_for(NUM_LINES);
    localparam int PADDED = NWORDS * WORD_W;
    localparam logic [PADDED-1:0] VALID = PADDED'(line_valid(NUM_LINES));

    reg_sel_t          sel;
    logic [PADDED-1:0] mask_q;
    logic [PADDED-1:0] pol_q;
    logic [PADDED-1:0] ack_pad;
    logic [WORD_W-1:0] rd_word;

    assign sel = decode_addr(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= VALID;
            pol_q  <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (sel.word == 2'(w)) begin
                    case (sel.bank)
                        BANK_MASK: mask_q[w*WORD_W +: WORD_W] <= reg_wdata & VALID[w*WORD_W +: WORD_W];
                        BANK_POL:  pol_q[w*WORD_W +: WORD_W]  <= reg_wdata & VALID[w*WORD_W +: WORD_W];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        ack_pad = '0;
        if (reg_wr && sel.bank == BANK_ACK) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (sel.word == 2'(w))
                    ack_pad[w*WORD_W +: WORD_W] = reg_wdata & VALID[w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (sel.word == 2'(w)) begin
                case (sel.bank)
                    BANK_MASK: rd_word = mask_q[w*WORD_W +: WORD_W];
                    BANK_POL:  rd_word = pol_q[w*WORD_W +: WORD_W];
                    default:   rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
        else             reg_rdata <= '0;
    end

    assign mask_vec = mask_q[NUM_LINES-1:0];
    assign pol_vec  = pol_q[NUM_LINES-1:0];
    assign ack_vec  = ack_pad[NUM_LINES-1:0];

    logic unused_pad;
    assign unused_pad = ^{mask_q, pol_q, ack_pad, reg_addr[1:0]};
endmodule

// File: rtl/ilf_line.sv
module ilf_line
    import ilf_pkg::*;
#(
    parameter bit IS_EDGE = 1'b1,
    parameter bit ACK_EN  = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_in,
    input  line_ctl_t ctl,
    output logic      pend,
    output logic      irq
);
    logic act;
    assign act = lvl_in ^ ctl.pol;

    if (IS_EDGE) begin : g_edge
        logic prev;
        logic rise;
        logic pend_n;

        assign rise = act & ~prev;

        if (ACK_EN) begin : g_ack
            assign pend_n = rise | (pend & ~ctl.ack);
        end else begin : g_noack
            assign pend_n = rise | (pend & act);
            logic unused_ack;
            assign unused_ack = ctl.ack;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev <= 1'b0;
                pend <= 1'b0;
            end else begin
                prev <= act;
                pend <= pend_n;
            end
        end

        assign irq = pend & ~ctl.mask;
    end else begin : g_level
        assign pend = 1'b0;
        assign irq  = act & ~ctl.mask;
        logic unused_lvl;
        assign unused_lvl = ^{ctl.ack, clk, rst};
    end
endmodule

// File: rtl/irq_level_front.sv
module irq_level_front
    import ilf_pkg::*;
#(
    parameter int                   NUM_LINES  = 64,
    parameter logic [MAX_LINES-1:0] EDGE_LINES = {MAX_LINES{1'b1}},
    parameter bit                   ACK_EN     = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);
    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_count
        $error("irq_level_front: NUM_LINES out of range");
    end

    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] mask_vec;
    logic [NUM_LINES-1:0] pol_vec;
    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] pend_vec;

    ilf_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (irq_raw),
        .q_sync  (sync_vec)
    );

    ilf_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask_vec  (mask_vec),
        .pol_vec   (pol_vec),
        .ack_vec   (ack_vec)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        line_ctl_t ctl;
        assign ctl = '{pol: pol_vec[i], mask: mask_vec[i], ack: ack_vec[i]};

        ilf_line #(
            .IS_EDGE (EDGE_LINES[i]),
            .ACK_EN  (ACK_EN)
        ) u_line (
            .clk    (clk),
            .rst    (rst),
            .lvl_in (sync_vec[i]),
            .ctl    (ctl),
            .pend   (pend_vec[i]),
            .irq    (irq_out[i])
        );
    end
endmodule

// File: rtl/ilf_chk.sv
module ilf_chk
    import ilf_pkg::*;
#(
    parameter int                   NUM_LINES  = 64,
    parameter logic [MAX_LINES-1:0] EDGE_LINES = {MAX_LINES{1'b1}},
    parameter bit                   ACK_EN     = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_rd,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [NUM_LINES-1:0] mask_vec,
    input logic [NUM_LINES-1:0] pol_vec,
    input logic [NUM_LINES-1:0] sync_vec,
    input logic [NUM_LINES-1:0] pend_vec,
    input logic [NUM_LINES-1:0] ack_vec
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0)); // R3

    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_rd) && $past(reg_addr[5:4]) == 2'b10) |-> (reg_rdata == '0)); // R9

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_rd) |-> (reg_rdata == '0)); // R11

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            mask_vec[i] |-> !irq_out[i]); // R4

        if (EDGE_LINES[i] && ACK_EN) begin : g_hold
            AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (pend_vec[i] && !ack_vec[i]) |=> pend_vec[i]); // R7
        end else if (EDGE_LINES[i]) begin : g_drop
            AST_NOACK_DROP: assert property (@(posedge clk) disable iff (rst)
                (pend_vec[i] && !(sync_vec[i] ^ pol_vec[i])) |=> !pend_vec[i]); // R10
        end else begin : g_lvl
            AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (rst)
                ($stable(sync_vec[i]) && $stable(pol_vec[i]) && $stable(mask_vec[i]))
                |-> $stable(irq_out[i])); // R6
        end
    end
endmodule

bind irq_level_front ilf_chk #(
    .NUM_LINES  (NUM_LINES),
    .EDGE_LINES (EDGE_LINES),
    .ACK_EN     (ACK_EN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .mask_vec  (mask_vec),
    .pol_vec   (pol_vec),
    .sync_vec  (sync_vec),
    .pend_vec  (pend_vec),
    .ack_vec   (ack_vec)
);

// File: tb/irq_level_front_tb.sv
module irq_level_front_tb;
    localparam int          NL   = 20;
    localparam logic [63:0] EDGE = 64'h0000_0000_000F_FFF0; // lines 0-3 level, 4-19 edge
    localparam int          NVEC = 8;
    // {pol[3:0], mask[3:0], raw[3:0], expected irq_out[3:0]} for level lines 0..3
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00FF, 16'h0055, 16'hF05A, 16'h03FC,
        16'h3003, 16'hFF00, 16'h6835, 16'h0000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] raw = '0;
    logic [5:0]    addr = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata_a, rdata_b;
    logic [NL-1:0] out_a, out_b;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    irq_level_front #(.NUM_LINES(NL), .EDGE_LINES(EDGE), .ACK_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .irq_raw(raw), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata_a), .irq_out(out_a));

    irq_level_front #(.NUM_LINES(NL), .EDGE_LINES(EDGE), .ACK_EN(1'b0)) u_dut_noack (
        .clk(clk), .rst(rst), .irq_raw(raw), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata_b), .irq_out(out_b));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [15:0] va, output logic [15:0] vb);
        addr = a; rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        va = rdata_a;
        vb = rdata_b;
    endtask

    initial begin
        logic [15:0] ra, rb;
        tick(3);
        rst = 1'b0;
        tick(1);

        // reset state
        check("R3 outputs low", out_a, 0);
        reg_read(6'h00, ra, rb);
        check("R3 mask word0", ra, 16'hFFFF);
        reg_read(6'h04, ra, rb);
        check("R1 mask word1 partial", ra, 16'h000F);
        reg_read(6'h10, ra, rb);
        check("R3 polarity word0", ra, 16'h0000);
        reg_read(6'h20, ra, rb);
        check("R9 ack reads zero", ra, 16'h0000);
        tick(1);
        check("R11 idle rdata zero", rdata_a, 16'h0000);

        // table walk over level lines
        for (int k = 0; k < NVEC; k++) begin
            reg_write(6'h00, {12'hFFF, VEC[k][11:8]});
            reg_write(6'h10, {12'h000, VEC[k][15:12]});
            raw[3:0] = VEC[k][7:4];
            tick(3);
            check($sformatf("R6 R5 R4 level vector %0d", k), out_a[3:0], VEC[k][3:0]);
        end

        raw = '0;
        reg_write(6'h00, 16'h0000);
        reg_write(6'h04, 16'h0000);
        reg_write(6'h10, 16'h0000);
        tick(3);

        // level latency: two edges
        raw[0] = 1'b1;
        tick(1);
        check("R6 not yet after one edge", out_a[0], 0);
        tick(1);
        check("R6 after two edges", out_a[0], 1);
        raw[0] = 1'b0;
        tick(2);

        // edge line 4 latch
        raw[4] = 1'b1;
        tick(1);
        raw[4] = 1'b0;
        tick(2);
        check("R7 edge latched", out_a[4], 1);
        check("R10 noack pend while active", out_b[4], 1);
        tick(1);
        check("R10 noack clears when inactive", out_b[4], 0);
        check("R7 held after input drops", out_a[4], 1);
        tick(5);
        check("R7 still held", out_a[4], 1);
        reg_write(6'h20, 16'h0020);
        check("R8 other ack bit no effect", out_a[4], 1);
        reg_write(6'h20, 16'h0010);
        check("R8 ack clears", out_a[4], 0);

        // line 5 held high, ack in both variants
        raw[5] = 1'b1;
        tick(4);
        check("R7 line5 latched", out_a[5], 1);
        check("R10 line5 noack active", out_b[5], 1);
        reg_write(6'h20, 16'h0020);
        check("R8 ack clears while input high", out_a[5], 0);
        check("R10 ack ignored", out_b[5], 1);
        raw[5] = 1'b0;
        tick(3);
        check("R10 clears after input inactive", out_b[5], 0);

        // line 6: ack coinciding with a new edge
        raw[6] = 1'b1;
        tick(1);
        raw[6] = 1'b0;
        tick(4);
        check("R7 line6 pending", out_a[6], 1);
        raw[6] = 1'b1;
        tick(2);
        reg_write(6'h20, 16'h0040);
        check("R8 same-cycle edge keeps pending", out_a[6], 1);
        reg_write(6'h20, 16'h0040);
        check("R8 later ack clears", out_a[6], 0);
        raw[6] = 1'b0;

        // line 7: masked capture
        reg_write(6'h00, 16'h0080);
        raw[7] = 1'b1;
        tick(1);
        raw[7] = 1'b0;
        tick(4);
        check("R4 masked edge hidden", out_a[7], 0);
        reg_write(6'h00, 16'h0000);
        check("R4 unmask reveals pending", out_a[7], 1);
        reg_write(6'h20, 16'h0080);
        check("R8 line7 cleared", out_a[7], 0);

        // line 8: inverted polarity on an edge line
        raw[8] = 1'b1;
        tick(4);
        check("R5 rising edge with pol 0", out_a[8], 1);
        reg_write(6'h10, 16'h0100);
        reg_write(6'h20, 16'h0100);
        check("R8 line8 cleared", out_a[8], 0);
        tick(3);
        check("R5 no edge from inversion", out_a[8], 0);
        raw[8] = 1'b0;
        tick(3);
        check("R5 falling edge active with pol 1", out_a[8], 1);
        reg_write(6'h20, 16'h0100);
        reg_read(6'h10, ra, rb);
        check("R2 polarity readback", ra, 16'h0100);

        // line 17: upper word addressing
        raw[17] = 1'b1;
        tick(1);
        raw[17] = 1'b0;
        tick(4);
        check("R7 line17 latched", out_a[17], 1);
        reg_write(6'h20, 16'h0002);
        check("R2 word0 ack misses line17", out_a[17], 1);
        reg_write(6'h24, 16'h0002);
        check("R2 word1 ack clears line17", out_a[17], 0);

        // nonexistent bits and words
        reg_write(6'h04, 16'hFFFF);
        reg_read(6'h04, ra, rb);
        check("R1 absent bits read zero", ra, 16'h000F);
        reg_write(6'h08, 16'hFFFF);
        reg_read(6'h08, ra, rb);
        check("R1 absent word reads zero", ra, 16'h0000);
        reg_read(6'h24, ra, rb);
        check("R9 ack word1 reads zero", ra, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule